// File: doc/BRIEF.md
# I2C Bus Time-Out Monitor

This block sits beside an I2C host engine and polices how long the clock line may stay low and how long the bus may sit without any edge. It samples already-synchronized SCL and SDA levels and finds START and STOP conditions on its own. From these it keeps a bus-busy state. It runs four tick counters in parallel, all clocked by a free-running time-base tick:

- a continuous SCL-low counter;
- a cumulative SCL-low counter that spans a whole transaction;
- a cumulative SCL-low counter that restarts at each ACK slot;
- a bus-inactivity counter.

When any of the three SCL-low rules is broken, the block sends the engine a one-cycle request to drop its clock hold and finish with an automatic STOP. It also sets sticky status flags. When the inactivity rule is broken, it pulses a force-idle output and returns its own bus state to idle. Every threshold is a parameter counted in time-base ticks.

Top module: `i2c_tmo_monitor`

## Requirements
- R1: With `low_en_i` high, when SCL stays low for `LOW_TICKS` ticks in a row, `release_stop_o` pulses for one cycle, at the clock edge that counts the last tick. A high SCL level restarts the count. Cycles without `tick_i` add nothing. Only one pulse is given per low stretch.
- R2: An SCL-low time-out sets both `sts_low_o` and `sts_berr_o`. It leaves `sts_ext_o` unchanged.
- R3: A START is SDA falling while SCL is high across two samples. A STOP is SDA rising while SCL is high. START sets `bus_busy_o`, and STOP clears it. SDA changes while SCL is low do not change `bus_busy_o`.
- R4: With `cext_en_i` high, the block adds up SCL-low ticks while the bus is busy. The total is cleared at START. When the total first exceeds `CEXT_TICKS`, `release_stop_o` pulses once, and `sts_ext_o` and `sts_berr_o` are set. SCL-low time outside a transaction is not counted.
- R5: With `hext_en_i` high, the block adds up SCL-low ticks while the bus is busy. This total is cleared at START and on every `ack_slot_i` pulse. When the total within one segment exceeds `HEXT_TICKS`, `release_stop_o` pulses once, and `sts_ext_o` and `sts_berr_o` are set.
- R6: `inact_sel_i` selects the inactivity limit: 0 turns it off, 1 gives 5, 2 gives 10 and 3 gives 20 times `INACT_UNIT` ticks. The count runs while the bus is busy and neither line changes, including while SCL is held low. On reaching the limit, `force_idle_o` pulses for one cycle and `bus_busy_o` goes low. No status flag is set.
- R7: Status flags stay set until cleared by writing one to `clr_i`. Bit 0 clears `sts_low_o`, bit 1 clears `sts_ext_o` and bit 2 clears `sts_berr_o`. A new set in the same cycle wins over a clear.
- R8: While a time-out is disabled, its counter is held at zero and raises nothing. Enabling it again starts from zero.
- R9: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| ack_slot_i | input | 1 | One-cycle pulse per ACK bit slot from the host engine |
| tick_i | input | 1 | Time-base tick enable |
| low_en_i | input | 1 | Enable continuous SCL-low time-out |
| cext_en_i | input | 1 | Enable per-transaction extend time-out |
| hext_en_i | input | 1 | Enable per-segment extend time-out |
| inact_sel_i | input | 2 | Inactivity limit select (0 off, 1/2/3 = 5/10/20 units) |
| clr_i | input | 3 | Write-one-to-clear for status flags (bit0 low, bit1 ext, bit2 berr) |
| release_stop_o | output | 1 | One-cycle request to release clock hold and send STOP |
| force_idle_o | output | 1 | One-cycle pulse forcing bus state to idle |
| bus_busy_o | output | 1 | Bus busy between START and STOP |
| sts_low_o | output | 1 | Sticky SCL-low time-out flag |
| sts_ext_o | output | 1 | Sticky extend time-out flag |
| sts_berr_o | output | 1 | Sticky bus-error flag |

## Verification
The assertions check several rules on every cycle:

- a cleared counter reads zero on the next cycle;
- a counter never climbs past its limit while that limit is steady;
- START and STOP are never seen together;
- every release request comes with a set bus-error flag;
- a low-time-out flag never rises alone;
- flags hold unless cleared;
- a force-idle pulse leaves the bus idle.

The exact firing cycle of each time-out can only be shown by the bench's scenarios. The same holds for the sum across SCL-low stretches broken by high phases, the restart on each ACK pulse, the tick gating and the mapping of the inactivity select codes.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;

  localparam int unsigned NCH   = 4;
  localparam int unsigned CH_LOW  = 0;
  localparam int unsigned CH_CEXT = 1;
  localparam int unsigned CH_HEXT = 2;
  localparam int unsigned CH_INACT = 3;

  localparam int unsigned CLR_LOW  = 0;
  localparam int unsigned CLR_EXT  = 1;
  localparam int unsigned CLR_BERR = 2;

  typedef enum logic [1:0] {
    INACT_OFF   = 2'd0,
    INACT_SHORT = 2'd1,
    INACT_MID   = 2'd2,
    INACT_LONG  = 2'd3
  } inact_sel_e;

  // Multiplier of the inactivity unit for each select code.
  function automatic int unsigned inact_units(input logic [1:0] sel);
    case (inact_sel_e'(sel))
      INACT_SHORT: return 5;
      INACT_MID:   return 10;
      INACT_LONG:  return 20;
      default:     return 0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic activity_o
);

  logic scl_q;
  logic sda_q;

  // Idle lines are high, so the history resets high to avoid false edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o    = scl_q & scl_i & sda_q & ~sda_i;
    stop_o     = scl_q & scl_i & ~sda_q & sda_i;
    activity_o = (scl_q ^ scl_i) | (sda_q ^ sda_i);
  end

  a_r3_start_stop_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));

endmodule

// File: rtl/i2c_tmo_counter.sv
module i2c_tmo_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);

  logic [W-1:0] cnt;
  logic [W-1:0] last;

  always_comb begin
    last  = limit_i - W'(1);
    hit_o = ~clr_i & inc_i & (limit_i != '0) & (cnt == last);
  end

  // Saturates at the limit so one stretch fires only once.
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt <= '0;
    end else if (inc_i && (cnt < limit_i)) begin
      cnt <= cnt + W'(1);
    end
  end

  a_r8_cleared_zero: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt == '0));

  a_r8_bounded: assert property (@(posedge clk) disable iff (rst)
    ((cnt <= limit_i) && $stable(limit_i)) |=> (cnt <= $past(limit_i)));

endmodule

// File: rtl/i2c_tmo_monitor.sv
module i2c_tmo_monitor
  import i2c_tmo_pkg::*;
#(
  parameter int unsigned LOW_TICKS  = 30,
  parameter int unsigned CEXT_TICKS = 25,
  parameter int unsigned HEXT_TICKS = 10,
  parameter int unsigned INACT_UNIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       ack_slot_i,
  input  logic       tick_i,
  input  logic       low_en_i,
  input  logic       cext_en_i,
  input  logic       hext_en_i,
  input  logic [1:0] inact_sel_i,
  input  logic [2:0] clr_i,
  output logic       release_stop_o,
  output logic       force_idle_o,
  output logic       bus_busy_o,
  output logic       sts_low_o,
  output logic       sts_ext_o,
  output logic       sts_berr_o
);

  localparam int unsigned M1 = (LOW_TICKS > CEXT_TICKS + 1) ? LOW_TICKS : CEXT_TICKS + 1;
  localparam int unsigned M2 = (M1 > HEXT_TICKS + 1) ? M1 : HEXT_TICKS + 1;
  localparam int unsigned M3 = (M2 > 20 * INACT_UNIT) ? M2 : 20 * INACT_UNIT;
  localparam int unsigned CW = $clog2(M3 + 1);

  logic start, stop, activity;
  logic busy_q;

  logic [NCH-1:0] ch_clr;
  logic [NCH-1:0] ch_inc;
  logic [NCH-1:0] ch_hit;
  logic [CW-1:0]  ch_lim [NCH];

  i2c_bus_cond u_cond (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start),
    .stop_o     (stop),
    .activity_o (activity)
  );

  // Per-channel clear, count and limit.
  always_comb begin
    ch_clr[CH_LOW]   = ~low_en_i | scl_i;
    ch_inc[CH_LOW]   = tick_i & ~scl_i;
    ch_lim[CH_LOW]   = CW'(LOW_TICKS);

    ch_clr[CH_CEXT]  = ~cext_en_i | start;
    ch_inc[CH_CEXT]  = tick_i & ~scl_i & busy_q;
    ch_lim[CH_CEXT]  = CW'(CEXT_TICKS + 1);

    ch_clr[CH_HEXT]  = ~hext_en_i | start | ack_slot_i;
    ch_inc[CH_HEXT]  = tick_i & ~scl_i & busy_q;
    ch_lim[CH_HEXT]  = CW'(HEXT_TICKS + 1);

    ch_clr[CH_INACT] = (inact_sel_i == INACT_OFF) | activity | ~busy_q;
    ch_inc[CH_INACT] = tick_i;
    ch_lim[CH_INACT] = CW'(inact_units(inact_sel_i) * INACT_UNIT);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    i2c_tmo_counter #(.W(CW)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (ch_clr[g]),
      .inc_i   (ch_inc[g]),
      .limit_i (ch_lim[g]),
      .hit_o   (ch_hit[g])
    );
  end

  logic low_hit, ext_hit, inact_hit;
  always_comb begin
    low_hit   = ch_hit[CH_LOW];
    ext_hit   = ch_hit[CH_CEXT] | ch_hit[CH_HEXT];
    inact_hit = ch_hit[CH_INACT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q         <= 1'b0;
      release_stop_o <= 1'b0;
      force_idle_o   <= 1'b0;
      sts_low_o      <= 1'b0;
      sts_ext_o      <= 1'b0;
      sts_berr_o     <= 1'b0;
    end else begin
      if (inact_hit)  busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      else if (stop)  busy_q <= 1'b0;
      release_stop_o <= low_hit | ext_hit;
      force_idle_o   <= inact_hit;
      sts_low_o  <= low_hit | (sts_low_o & ~clr_i[CLR_LOW]);
      sts_ext_o  <= ext_hit | (sts_ext_o & ~clr_i[CLR_EXT]);
      sts_berr_o <= low_hit | ext_hit | (sts_berr_o & ~clr_i[CLR_BERR]);
    end
  end

  assign bus_busy_o = busy_q;

  a_r2_low_with_berr: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_low_o) |-> sts_berr_o);

  a_r4_release_berr: assert property (@(posedge clk) disable iff (rst)
    release_stop_o |-> sts_berr_o);

  a_r7_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    (sts_ext_o && !clr_i[CLR_EXT]) |=> sts_ext_o);

  a_r7_low_sticky: assert property (@(posedge clk) disable iff (rst)
    (sts_low_o && !clr_i[CLR_LOW]) |=> sts_low_o);

  a_r6_idle_after_force: assert property (@(posedge clk) disable iff (rst)
    force_idle_o |-> !bus_busy_o);

endmodule

// File: tb/i2c_tmo_monitor_tb.sv
`timescale 1ns/1ps
module i2c_tmo_monitor_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, ack = 1'b0, tick = 1'b1;
  logic low_en = 1'b0, cext_en = 1'b0, hext_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [2:0] clr = 3'd0;
  logic rel, fidle, busy, s_low, s_ext, s_berr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  i2c_tmo_monitor u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .ack_slot_i(ack),
    .tick_i(tick), .low_en_i(low_en), .cext_en_i(cext_en), .hext_en_i(hext_en),
    .inact_sel_i(sel), .clr_i(clr), .release_stop_o(rel), .force_idle_o(fidle),
    .bus_busy_o(busy), .sts_low_o(s_low), .sts_ext_o(s_ext), .sts_berr_o(s_berr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next fall.
  task automatic step(input logic c, input logic d, input logic a);
    scl = c; sda = d; ack = a;
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic clear_flags();
    clr = 3'b111;
    step(scl, sda, 1'b0);
    clr = 3'b000;
  endtask

  task automatic do_start();
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic do_stop();
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk("R9", "release", rel, 0);
    chk("R9", "force_idle", fidle, 0);
    chk("R9", "busy", busy, 0);
    chk("R9", "flags", {s_low, s_ext, s_berr}, 0);
  endtask

  task automatic t_low_basic();
    int first = 0, pulses = 0;
    low_en = 1'b1;
    for (int i = 1; i <= 35; i++) begin
      step(1'b0, 1'b1, 1'b0);
      if (rel) begin pulses++; if (first == 0) first = i; end
    end
    chk("R1", "low fire step", first, 30);
    chk("R1", "low pulse count", pulses, 1);
    chk("R2", "sts_low", s_low, 1);
    chk("R2", "sts_berr", s_berr, 1);
    chk("R2", "sts_ext", s_ext, 0);
    step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_w1c();
    clr = 3'b001; step(1'b1, 1'b1, 1'b0); clr = 3'b000;
    chk("R7", "low cleared", s_low, 0);
    chk("R7", "berr kept", s_berr, 1);
    clr = 3'b100; step(1'b1, 1'b1, 1'b0); clr = 3'b000;
    chk("R7", "berr cleared", s_berr, 0);
  endtask

  task automatic t_low_gating();
    int pulses = 0, first = 0;
    clear_flags();
    low_en = 1'b0;
    for (int i = 0; i < 40; i++) begin step(1'b0, 1'b1, 1'b0); pulses += rel; end
    chk("R8", "disabled low no pulse", pulses, 0);
    chk("R8", "disabled low no flag", s_low, 0);
    step(1'b1, 1'b1, 1'b0);
    low_en = 1'b1;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin step(1'b0, 1'b1, 1'b0); pulses += rel; end
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin step(1'b0, 1'b1, 1'b0); pulses += rel; end
    low_en = 1'b0; step(1'b0, 1'b1, 1'b0); low_en = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1'b0, 1'b1, 1'b0); pulses += rel; end
    chk("R1", "broken or re-enabled low no pulse", pulses, 0);
    step(1'b1, 1'b1, 1'b0);
    pulses = 0;
    for (int i = 1; i <= 64; i++) begin
      tick = (i % 2 == 0);
      step(1'b0, 1'b1, 1'b0);
      if (rel) begin pulses++; if (first == 0) first = i; end
    end
    tick = 1'b1;
    chk("R1", "sparse tick fire step", first, 60);
    chk("R1", "sparse tick pulse count", pulses, 1);
    step(1'b1, 1'b1, 1'b0);
    low_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_cext();
    int lows = 0, fire_at = 0, pulses = 0;
    cext_en = 1'b1;
    do_start();
    chk("R3", "busy after START", busy, 1);
    for (int i = 0; i < 40; i++) begin
      if ((i % 10) < 8) begin
        step(1'b0, 1'b0, 1'b0); lows++;
      end else begin
        step(1'b1, 1'b0, 1'b0);
      end
      if (rel) begin pulses++; if (fire_at == 0) fire_at = lows; end
    end
    chk("R4", "cumulative fire low count", fire_at, 26);
    chk("R4", "pulse count", pulses, 1);
    chk("R4", "sts_ext", s_ext, 1);
    chk("R4", "sts_berr", s_berr, 1);
    chk("R4", "sts_low untouched", s_low, 0);
    do_stop();
    chk("R3", "idle after STOP", busy, 0);
    clear_flags();
    pulses = 0;
    for (int i = 0; i < 40; i++) begin step(1'b0, 1'b1, 1'b0); pulses += rel; end
    chk("R4", "no count outside transaction", pulses, 0);
    step(1'b1, 1'b1, 1'b0);
    cext_en = 1'b0;
  endtask

  task automatic t_hext();
    int pulses = 0, lows = 0, fire_at = 0;
    clear_flags();
    hext_en = 1'b1;
    do_start();
    for (int s = 0; s < 5; s++) begin
      for (int i = 0; i < 4; i++) begin step(1'b0, 1'b0, 1'b0); pulses += rel; end
      step(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin step(1'b0, 1'b0, 1'b0); pulses += rel; end
      step(1'b1, 1'b0, 1'b1);
    end
    chk("R5", "ACK restarts segment", pulses, 0);
    chk("R5", "no flag while acked", s_ext, 0);
    for (int i = 0; i < 20; i++) begin
      if ((i % 5) < 4) begin step(1'b0, 1'b0, 1'b0); lows++; end
      else step(1'b1, 1'b0, 1'b0);
      if (rel) begin pulses++; if (fire_at == 0) fire_at = lows; end
    end
    chk("R5", "segment fire low count", fire_at, 11);
    chk("R5", "pulse count", pulses, 1);
    chk("R5", "sts_ext and berr", {s_ext, s_berr}, 3);
    do_stop();
    hext_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_detect();
    step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b1, 1'b0);
    chk("R3", "SDA toggles with SCL low stay idle", busy, 0);
    do_start();
    step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b0, 1'b0);
    chk("R3", "SDA toggles with SCL low stay busy", busy, 1);
    do_stop();
    chk("R3", "STOP ends transaction", busy, 0);
  endtask

  task automatic inact_run(input logic [1:0] s, input logic hold_scl, input int exp_step);
    int first = 0, pulses = 0;
    sel = s;
    do_start();
    for (int i = 1; i <= 110; i++) begin
      step(hold_scl, 1'b0, 1'b0);
      if (fidle) begin pulses++; if (first == 0) first = i; end
    end
    chk("R6", $sformatf("sel %0d fire step", s), first, exp_step);
    chk("R6", $sformatf("sel %0d pulses", s), pulses, exp_step == 0 ? 0 : 1);
    chk("R6", $sformatf("sel %0d busy", s), busy, exp_step == 0 ? 1 : 0);
    chk("R6", "no flags", {s_low, s_ext, s_berr, rel}, 0);
    do_stop();
  endtask

  task automatic t_inact();
    inact_run(2'd1, 1'b1, 20);
    inact_run(2'd3, 1'b1, 80);
    inact_run(2'd2, 1'b0, 41);
    inact_run(2'd0, 1'b1, 0);
    sel = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_low_basic();
    t_w1c();
    t_low_gating();
    t_cext();
    t_hext();
    t_detect();
    t_inact();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule